// File: doc/BRIEF.md
# QSPI-Triggered Fault-Injection Sequencer

This block runs repeated fault-injection attempts against a target that boots from external QSPI flash. It listens to the target's QSPI bus without driving it, oversampling clock, chip select and the four data lines in the system clock domain. It decodes the command and the 24-bit address of every quad read. Its outputs are a power enable for the target, a select line that picks one of two flash devices, and a single pulse that fires an external pulse driver.

Each attempt has a fixed order. The target is first held unpowered with the first flash selected, then powered. When the chosen trigger read completes, the block switches to the second flash, waits a programmable delay, and emits the pulse. It then watches the reads that follow. A read that lands inside any configured address window counts as a success: the target stays powered and the sequencer parks. If no such read arrives, the target is powered off and a new attempt begins.

The delay is swept in hardware from one failed attempt to the next. This spreads the pulse across the target's boot-time jitter. The states are IDLE, OFF, BOOT, DELAY, PULSE, WATCH and DONE. The transitions are:
- IDLE to OFF on start.
- OFF to BOOT when the off time expires.
- BOOT to DELAY on trigger, or BOOT to PULSE on trigger when the delay is zero.
- BOOT to OFF on boot timeout.
- DELAY to PULSE when the delay expires.
- PULSE to WATCH when the width expires.
- WATCH to DONE on a window hit.
- WATCH to OFF on post timeout.
- DONE stays in DONE.

Top module: `fi_sequencer`

## Requirements
- R1: After reset, power enable, flash select, pulse and done are all 0, the result code is 0 (none) and the attempt count is 0.
- R2: A start in IDLE holds power off with flash select 0 for max(cfg_off_cycles,1) cycles. Power then rises while flash select stays 0. Flash select is never 1 while power is off.
- R3: A read is decoded as follows. While chip select is low, the first 8 rising SCK edges carry the command on IO0, MSB first. The next 6 edges carry the address as nibbles on IO[3:0], MSB nibble first. The read qualifies only if the command is 0xEB and at least one further SCK edge occurs before chip select rises.
- R4: A qualifying read whose address equals cfg_trig_addr is the trigger. Flash select rises exactly 4 clock cycles after the input cycle in which chip select rises. Reads with other addresses, wrong commands or no data nibble do not trigger.
- R5: The pulse rises exactly d cycles after flash select rises, where d is the current delay. With d = 0 both rise in the same cycle.
- R6: The pulse stays high for exactly max(cfg_pulse_width,1) cycles. It is only ever high while power is on and flash select is 1.
- R7: In WATCH, a qualifying read whose address a satisfies base <= a < base+len for any window with nonzero len moves the block to DONE with result code 1 (pass). Done rises 4 cycles after chip select rises. The window end address itself does not match.
- R8: If no qualifying window read arrives in WATCH, the attempt ends max(cfg_post_cycles,1) cycles after the pulse falls. The result code becomes 2 (fail), power drops and a new attempt starts in OFF. Non-window reads do not end the attempt.
- R9: If no trigger arrives, power stays on for exactly max(cfg_boot_cycles,1) cycles. The result code then becomes 3 (timeout) and a new attempt starts in OFF.
- R10: Start loads the current delay with cfg_delay_base. Each fail adds cfg_delay_step, and a sum above cfg_delay_max reloads cfg_delay_base. A timeout leaves the delay unchanged.
- R11: The attempt count rises by exactly one each time an attempt ends with pass, fail or timeout.
- R12: DONE is permanent until reset. Start and bus activity leave done, power and flash select at 1, leave the pulse at 0 and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the attempt loop when in IDLE |
| qspi_sck | input | 1 | Snooped QSPI clock |
| qspi_cs_n | input | 1 | Snooped QSPI chip select, active low |
| qspi_io | input | 4 | Snooped QSPI data lines |
| cfg_off_cycles | input | TW | Power-off time per attempt |
| cfg_boot_cycles | input | TW | Boot timeout waiting for the trigger |
| cfg_post_cycles | input | TW | Post-pulse watch timeout |
| cfg_delay_base | input | DW | First delay of the sweep |
| cfg_delay_step | input | DW | Delay increment after each fail |
| cfg_delay_max | input | DW | Largest delay before the sweep wraps |
| cfg_pulse_width | input | PW | Pulse width in cycles |
| cfg_trig_addr | input | AW | Address of the trigger read |
| cfg_win_base | input | NW*AW | Window base addresses, window 0 in the low bits |
| cfg_win_len | input | NW*AW | Window lengths, 0 disables a window |
| flash_sel | output | 1 | 0 selects the first flash, 1 the second |
| tgt_power_en | output | 1 | Target power enable |
| pulse_out | output | 1 | Fault pulse |
| done | output | 1 | High once an attempt has passed |
| last_result | output | 2 | Result of the last attempt: 0 none, 1 pass, 2 fail, 3 timeout |
| attempt_count | output | CW | Number of finished attempts |

## Verification
A chip-select rise reaches the controller through two synchronizer stages and one registered read strobe. Its effect (flash select rising on a trigger, done rising on a window hit) therefore shows up on the 4th clock edge after the input changes. The bench timestamps that input cycle and compares it against the edge counts it records for each output transition. The bench also checks other durations as exact differences between recorded edges: the off time (start plus one), the boot wait, the delay, the pulse width and the watch timeout. The expected values come from the configuration, and the bench's own model of the delay sweep supplies the delay for each attempt. Ignored reads are checked once each read has finished and its four-cycle window has passed, so that any wrong reaction would already be visible on the outputs.

// File: rtl/fi_pkg.sv
package fi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF,
        ST_BOOT,
        ST_DELAY,
        ST_PULSE,
        ST_WATCH,
        ST_DONE
    } fi_state_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_PASS    = 2'd1,
        RES_FAIL    = 2'd2,
        RES_TIMEOUT = 2'd3
    } fi_result_e;

endpackage

// File: rtl/fi_qspi_snoop.sv
// Passive quad-read decoder, oversampled in the system clock domain.
module fi_qspi_snoop #(
    parameter int          AW       = 24,
    parameter int          SYNC     = 2,
    parameter logic [7:0]  READ_CMD = 8'hEB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic [3:0]    io,
    output logic          rd_done,
    output logic [AW-1:0] rd_addr
);
    localparam int CMD_BITS  = 8;
    localparam int ADDR_NIB  = AW / 4;
    localparam int DATA_EDGE = CMD_BITS + ADDR_NIB;
    localparam int QUAL_EDGE = DATA_EDGE + 1;
    localparam int CW        = $clog2(QUAL_EDGE + 1);
    localparam logic [5:0] IDLE_BUS = 6'b010000;

    logic [5:0]    pipe [SYNC];
    logic          sck_s, cs_s, sck_q, cs_q;
    logic [3:0]    io_s;
    logic          sck_rise, cs_rise;
    logic [CW-1:0] edge_cnt;
    logic [7:0]    cmd_sr;
    logic [AW-1:0] addr_sr;

    // synchronizer chain: {sck, cs_n, io[3:0]}
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) pipe[i] <= IDLE_BUS;
        end else begin
            pipe[0] <= {sck, cs_n, io};
            for (int i = 1; i < SYNC; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign sck_s    = pipe[SYNC-1][5];
    assign cs_s     = pipe[SYNC-1][4];
    assign io_s     = pipe[SYNC-1][3:0];
    assign sck_rise = sck_s & ~sck_q;
    assign cs_rise  = cs_s & ~cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            edge_cnt <= '0;
            cmd_sr   <= '0;
            addr_sr  <= '0;
            rd_done  <= 1'b0;
            rd_addr  <= '0;
        end else begin
            sck_q   <= sck_s;
            cs_q    <= cs_s;
            rd_done <= 1'b0;
            if (cs_s) begin
                edge_cnt <= '0;
            end else if (sck_rise) begin
                if (edge_cnt < CW'(CMD_BITS))
                    cmd_sr <= {cmd_sr[6:0], io_s[0]};
                else if (edge_cnt < CW'(DATA_EDGE))
                    addr_sr <= {addr_sr[AW-5:0], io_s};
                if (edge_cnt != CW'(QUAL_EDGE))
                    edge_cnt <= edge_cnt + CW'(1);
            end
            if (cs_rise && cmd_sr == READ_CMD && edge_cnt == CW'(QUAL_EDGE)) begin
                rd_done <= 1'b1;
                rd_addr <= addr_sr;
            end
        end
    end

endmodule

// File: rtl/fi_window_match.sv
// Flags an address that lands inside any enabled window.
module fi_window_match #(
    parameter int AW = 24,
    parameter int NW = 3
) (
    input  logic [AW-1:0]    addr,
    input  logic [NW*AW-1:0] win_base,
    input  logic [NW*AW-1:0] win_len,
    output logic             hit
);
    logic [NW-1:0] hit_v;

    for (genvar w = 0; w < NW; w++) begin : g_win
        logic [AW-1:0] base_w, len_w, off_w;
        assign base_w   = win_base[w*AW +: AW];
        assign len_w    = win_len[w*AW +: AW];
        assign off_w    = addr - base_w;
        assign hit_v[w] = (len_w != '0) && (addr >= base_w) && (off_w < len_w);
    end

    assign hit = |hit_v;

endmodule

// File: rtl/fi_delay_sweep.sv
// Holds the delay of the running attempt and steps it after each fail.
module fi_delay_sweep #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] cur
);
    logic [DW:0] sum;

    assign sum = {1'b0, cur} + {1'b0, step};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur <= '0;
        else if (load)
            cur <= base;
        else if (advance)
            cur <= (sum > {1'b0, limit}) ? base : sum[DW-1:0];
    end

endmodule

// File: rtl/fi_sequencer.sv
// Attempt controller: power, flash swap, delayed pulse, success watch.
module fi_sequencer
    import fi_pkg::*;
#(
    parameter int         AW       = 24,
    parameter int         NW       = 3,
    parameter int         TW       = 24,
    parameter int         DW       = 16,
    parameter int         PW       = 8,
    parameter int         CW       = 32,
    parameter int         SYNC     = 2,
    parameter logic [7:0] READ_CMD = 8'hEB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             qspi_sck,
    input  logic             qspi_cs_n,
    input  logic [3:0]       qspi_io,
    input  logic [TW-1:0]    cfg_off_cycles,
    input  logic [TW-1:0]    cfg_boot_cycles,
    input  logic [TW-1:0]    cfg_post_cycles,
    input  logic [DW-1:0]    cfg_delay_base,
    input  logic [DW-1:0]    cfg_delay_step,
    input  logic [DW-1:0]    cfg_delay_max,
    input  logic [PW-1:0]    cfg_pulse_width,
    input  logic [AW-1:0]    cfg_trig_addr,
    input  logic [NW*AW-1:0] cfg_win_base,
    input  logic [NW*AW-1:0] cfg_win_len,
    output logic             flash_sel,
    output logic             tgt_power_en,
    output logic             pulse_out,
    output logic             done,
    output logic [1:0]       last_result,
    output logic [CW-1:0]    attempt_count
);
    localparam int TMW_A = (TW > DW) ? TW : DW;
    localparam int TMW   = (TMW_A > PW) ? TMW_A : PW;

    function automatic logic [TMW-1:0] dur(input logic [TMW-1:0] n);
        return (n == '0) ? '0 : n - TMW'(1);
    endfunction

    fi_state_e      st_q, st_nxt;
    fi_result_e     res_q, fin_res;
    logic [TMW-1:0] tmr_q, tmr_nxt;
    logic [CW-1:0]  cnt_q;
    logic           fin, sweep_load, sweep_adv;
    logic           rd_done, win_hit_raw, trig_hit, win_hit, tmr_zero;
    logic [AW-1:0]  rd_addr;
    logic [DW-1:0]  cur_delay;

    fi_qspi_snoop #(.AW(AW), .SYNC(SYNC), .READ_CMD(READ_CMD)) u_snoop (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (qspi_sck),
        .cs_n    (qspi_cs_n),
        .io      (qspi_io),
        .rd_done (rd_done),
        .rd_addr (rd_addr)
    );

    fi_window_match #(.AW(AW), .NW(NW)) u_win (
        .addr     (rd_addr),
        .win_base (cfg_win_base),
        .win_len  (cfg_win_len),
        .hit      (win_hit_raw)
    );

    fi_delay_sweep #(.DW(DW)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sweep_load),
        .advance (sweep_adv),
        .base    (cfg_delay_base),
        .step    (cfg_delay_step),
        .limit   (cfg_delay_max),
        .cur     (cur_delay)
    );

    assign trig_hit = rd_done && (rd_addr == cfg_trig_addr);
    assign win_hit  = rd_done && win_hit_raw;
    assign tmr_zero = (tmr_q == '0);

    // next state and timer load
    always_comb begin
        st_nxt     = st_q;
        tmr_nxt    = tmr_zero ? tmr_q : tmr_q - TMW'(1);
        fin        = 1'b0;
        fin_res    = RES_NONE;
        sweep_load = 1'b0;
        sweep_adv  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_nxt     = ST_OFF;
                    tmr_nxt    = dur(TMW'(cfg_off_cycles));
                    sweep_load = 1'b1;
                end
            end
            ST_OFF: begin
                if (tmr_zero) begin
                    st_nxt  = ST_BOOT;
                    tmr_nxt = dur(TMW'(cfg_boot_cycles));
                end
            end
            ST_BOOT: begin
                if (trig_hit) begin
                    if (cur_delay == '0) begin
                        st_nxt  = ST_PULSE;
                        tmr_nxt = dur(TMW'(cfg_pulse_width));
                    end else begin
                        st_nxt  = ST_DELAY;
                        tmr_nxt = dur(TMW'(cur_delay));
                    end
                end else if (tmr_zero) begin
                    st_nxt  = ST_OFF;
                    tmr_nxt = dur(TMW'(cfg_off_cycles));
                    fin     = 1'b1;
                    fin_res = RES_TIMEOUT;
                end
            end
            ST_DELAY: begin
                if (tmr_zero) begin
                    st_nxt  = ST_PULSE;
                    tmr_nxt = dur(TMW'(cfg_pulse_width));
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    st_nxt  = ST_WATCH;
                    tmr_nxt = dur(TMW'(cfg_post_cycles));
                end
            end
            ST_WATCH: begin
                if (win_hit) begin
                    st_nxt  = ST_DONE;
                    fin     = 1'b1;
                    fin_res = RES_PASS;
                end else if (tmr_zero) begin
                    st_nxt    = ST_OFF;
                    tmr_nxt   = dur(TMW'(cfg_off_cycles));
                    fin       = 1'b1;
                    fin_res   = RES_FAIL;
                    sweep_adv = 1'b1;
                end
            end
            ST_DONE: begin
                st_nxt = ST_DONE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register, timer, result and attempt count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
            res_q <= RES_NONE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            tmr_q <= tmr_nxt;
            if (fin) begin
                res_q <= fin_res;
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Moore outputs
    always_comb begin
        flash_sel    = 1'b0;
        tgt_power_en = 1'b0;
        pulse_out    = 1'b0;
        done         = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_OFF: ;
            ST_BOOT: tgt_power_en = 1'b1;
            ST_DELAY, ST_WATCH: begin
                tgt_power_en = 1'b1;
                flash_sel    = 1'b1;
            end
            ST_PULSE: begin
                tgt_power_en = 1'b1;
                flash_sel    = 1'b1;
                pulse_out    = 1'b1;
            end
            ST_DONE: begin
                tgt_power_en = 1'b1;
                flash_sel    = 1'b1;
                done         = 1'b1;
            end
            default: ;
        endcase
    end

    assign last_result   = res_q;
    assign attempt_count = cnt_q;

endmodule

// File: rtl/fi_sequencer_chk.sv
// Output-level properties of the sequencer, bound to the top.
module fi_sequencer_chk #(
    parameter int PW = 8,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flash_sel,
    input logic          tgt_power_en,
    input logic          pulse_out,
    input logic          done,
    input logic [1:0]    last_result,
    input logic [CW-1:0] attempt_count,
    input logic [PW-1:0] cfg_pulse_width
);
    logic [PW:0] run_len;
    logic [PW:0] exp_len;

    assign exp_len = (cfg_pulse_width == '0) ? (PW+1)'(1) : {1'b0, cfg_pulse_width};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (pulse_out)
            run_len <= run_len + (PW+1)'(1);
        else
            run_len <= '0;
    end

    p_pulse_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> (tgt_power_en && flash_sel));

    p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> (run_len == exp_len));

    p_off_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_power_en |-> !flash_sel);

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_count != $past(attempt_count)) |->
            (attempt_count == $past(attempt_count) + CW'(1)));

    p_done_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_result == 2'd1));

    p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && tgt_power_en && flash_sel && !pulse_out && $stable(attempt_count)));

endmodule

bind fi_sequencer fi_sequencer_chk #(.PW(PW), .CW(CW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .flash_sel       (flash_sel),
    .tgt_power_en    (tgt_power_en),
    .pulse_out       (pulse_out),
    .done            (done),
    .last_result     (last_result),
    .attempt_count   (attempt_count),
    .cfg_pulse_width (cfg_pulse_width)
);

// File: tb/fi_sequencer_bench.sv
`timescale 1ns/1ps
module fi_sequencer_bench;
    localparam int AW = 24, NW = 3, TW = 24, DW = 16, PW = 8, CW = 32;
    localparam int HALF   = 2;
    localparam int OFFC   = 10;
    localparam int BOOTC  = 600;
    localparam int POSTC  = 300;
    localparam int DBASE  = 3, DSTEP = 2, DMAX = 6;
    localparam int WIDTH  = 3;
    localparam logic [23:0] TRIG = 24'h001234;
    localparam logic [7:0]  RCMD = 8'hEB;

    logic clk = 1'b0;
    logic rst_n, start, sck, cs_n;
    logic [3:0] io;
    logic flash_sel, tgt_power_en, pulse_out, done;
    logic [1:0] last_result;
    logic [CW-1:0] attempt_count;

    always #2 clk = ~clk;

    fi_sequencer #(.AW(AW), .NW(NW), .TW(TW), .DW(DW), .PW(PW), .CW(CW)) u_fi_sequencer (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .qspi_sck        (sck),
        .qspi_cs_n       (cs_n),
        .qspi_io         (io),
        .cfg_off_cycles  (TW'(OFFC)),
        .cfg_boot_cycles (TW'(BOOTC)),
        .cfg_post_cycles (TW'(POSTC)),
        .cfg_delay_base  (DW'(DBASE)),
        .cfg_delay_step  (DW'(DSTEP)),
        .cfg_delay_max   (DW'(DMAX)),
        .cfg_pulse_width (PW'(WIDTH)),
        .cfg_trig_addr   (TRIG),
        .cfg_win_base    ({24'h002000, 24'h007000, 24'h000000}),
        .cfg_win_len     ({24'h000040, 24'h000100, 24'h000010}),
        .flash_sel       (flash_sel),
        .tgt_power_en    (tgt_power_en),
        .pulse_out       (pulse_out),
        .done            (done),
        .last_result     (last_result),
        .attempt_count   (attempt_count)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit finished = 0;
    int pwr_rise, pwr_fall, fl_rise, pl_rise, pl_fall, dn_rise;
    logic pw_q = 0, fl_q = 0, pl_q = 0, dn_q = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tgt_power_en && !pw_q) pwr_rise = cyc;
        if (!tgt_power_en && pw_q) pwr_fall = cyc;
        if (flash_sel && !fl_q)    fl_rise  = cyc;
        if (pulse_out && !pl_q)    pl_rise  = cyc;
        if (!pulse_out && pl_q)    pl_fall  = cyc;
        if (done && !dn_q)         dn_rise  = cyc;
        pw_q = tgt_power_en; fl_q = flash_sel; pl_q = pulse_out; dn_q = done;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sck_edge(input logic [3:0] v);
        io = v;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic qspi_read(input logic [7:0] cmd, input logic [23:0] addr,
                             input int ndata, output int c_end);
        @(negedge clk);
        cs_n = 1'b0; sck = 1'b0;
        for (int i = 7; i >= 0; i--) sck_edge({3'b000, cmd[i]});
        for (int n = 5; n >= 0; n--) sck_edge(addr[n*4 +: 4]);
        for (int d = 0; d < ndata; d++) sck_edge(4'hA);
        repeat (HALF) @(negedge clk);
        cs_n  = 1'b1;
        c_end = cyc;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic wait_power(input logic lvl);
        while (tgt_power_en !== lvl) @(negedge clk);
        #1;
    endtask

    task automatic wait_pulse_done();
        while (pulse_out !== 1'b1) @(negedge clk);
        while (pulse_out !== 1'b0) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int ce, c0, exp_delay;
        rst_n = 1'b0; start = 1'b0; cs_n = 1'b1; sck = 1'b0; io = 4'h0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(tgt_power_en == 0, "R1 power", tgt_power_en, 0);
        check(flash_sel == 0, "R1 flash_sel", flash_sel, 0);
        check(pulse_out == 0, "R1 pulse", pulse_out, 0);
        check(done == 0, "R1 done", done, 0);
        check(last_result == 0, "R1 result", last_result, 0);
        check(attempt_count == 0, "R1 count", attempt_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 start and off time
        start = 1'b1; c0 = cyc;
        @(negedge clk);
        start = 1'b0;
        wait_power(1'b1);
        check(pwr_rise - c0 == OFFC + 1, "R2 off time", pwr_rise - c0, OFFC + 1);
        check(flash_sel == 0, "R2 first flash at power-on", flash_sel, 0);

        // attempt 1: ignored reads, then trigger
        exp_delay = DBASE;
        qspi_read(8'h6B, TRIG, 2, ce);
        check(flash_sel == 0, "R3 wrong command ignored", flash_sel, 0);
        qspi_read(RCMD, TRIG, 0, ce);
        check(flash_sel == 0, "R3 no data nibble ignored", flash_sel, 0);
        qspi_read(RCMD, TRIG + 24'h1, 2, ce);
        check(flash_sel == 0, "R4 other address ignored", flash_sel, 0);
        check(tgt_power_en == 1, "R4 still booting", tgt_power_en, 1);
        qspi_read(RCMD, TRIG, 3, ce);
        check(fl_rise - ce == 4, "R4 trigger latency", fl_rise - ce, 4);
        wait_pulse_done();
        check(pl_rise - fl_rise == exp_delay, "R5 delay", pl_rise - fl_rise, exp_delay);
        check(pl_fall - pl_rise == WIDTH, "R6 pulse width", pl_fall - pl_rise, WIDTH);
        qspi_read(RCMD, 24'h005000, 2, ce);
        check(done == 0, "R8 non-window read ignored", done, 0);
        wait_power(1'b0);
        check(last_result == 2, "R8 fail result", last_result, 2);
        check(flash_sel == 0, "R8 back to first flash", flash_sel, 0);
        check(attempt_count == 1, "R11 count after fail", attempt_count, 1);
        exp_delay = exp_delay + DSTEP;

        // attempt 2: boot timeout
        wait_power(1'b1);
        wait_power(1'b0);
        check(pwr_fall - pwr_rise == BOOTC, "R9 boot wait", pwr_fall - pwr_rise, BOOTC);
        check(last_result == 3, "R9 timeout result", last_result, 3);
        check(attempt_count == 2, "R11 count after timeout", attempt_count, 2);

        // attempt 3: delay advanced once, post timeout
        wait_power(1'b1);
        qspi_read(RCMD, TRIG, 2, ce);
        wait_pulse_done();
        check(pl_rise - fl_rise == exp_delay, "R10 swept delay", pl_rise - fl_rise, exp_delay);
        wait_power(1'b0);
        check(pwr_fall - pl_fall == POSTC, "R8 watch timeout", pwr_fall - pl_fall, POSTC);
        check(attempt_count == 3, "R11 count", attempt_count, 3);
        exp_delay = (exp_delay + DSTEP > DMAX) ? DBASE : exp_delay + DSTEP;

        // attempt 4: wrap, window edge, success
        wait_power(1'b1);
        qspi_read(RCMD, TRIG, 2, ce);
        wait_pulse_done();
        check(pl_rise - fl_rise == exp_delay, "R10 delay wrap", pl_rise - fl_rise, exp_delay);
        qspi_read(RCMD, 24'h002040, 2, ce);
        check(done == 0, "R7 window end excluded", done, 0);
        qspi_read(RCMD, 24'h007010, 2, ce);
        check(done == 1, "R7 done", done, 1);
        check(dn_rise - ce == 4, "R7 done latency", dn_rise - ce, 4);
        check(last_result == 1, "R7 pass result", last_result, 1);
        check(tgt_power_en == 1 && flash_sel == 1, "R7 target kept running",
              {tgt_power_en, flash_sel}, 3);
        check(attempt_count == 4, "R11 count after pass", attempt_count, 4);

        // R12 done is permanent
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        qspi_read(RCMD, TRIG, 2, ce);
        repeat (20) @(negedge clk);
        check(done == 1, "R12 done held", done, 1);
        check(tgt_power_en == 1, "R12 power held", tgt_power_en, 1);
        check(pulse_out == 0, "R12 no pulse", pulse_out, 0);
        check(attempt_count == 4, "R12 count frozen", attempt_count, 4);

        finished = 1;
        summary();
        $finish;
    end

endmodule